// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block decides, one address byte at a time, whether an I2C slave should acknowledge the bus master. A bit-level front end delivers each received byte with a one-cycle strobe and reports START (including repeated START) and STOP as one-cycle pulses. The recognizer compares the address bytes against a 10-bit own-address value. A per-bit don't-care mask applies to that compare. An accept-all mode overrides the mask, and the general call can be switched on or off. The block answers with registered acknowledge and match pulses.

Both short (7-bit) and two-byte long (10-bit) addressing are handled. In long mode the first byte is a header that carries the two upper address bits. The second byte carries the low eight bits. A later repeated START with a read header re-selects a slave that has already finished a long write-address match. Data bytes that follow a decision are left to the data path and ignored here.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, match_o, ack_o, gcall_o, rw_o and tenbit_busy_o are all 0.
- R2: In short mode, the first byte after a START carries the address in bits 7:1 and R/W in bit 0. When the address equals own_addr_i[6:0], match_o and ack_o pulse high in the clock after the strobe, and rw_o takes bit 0. match_o is never high without ack_o.
- R3: A 1 in addr_mask_i bit i makes own-address bit i don't-care. Short mode uses mask bits 6:0, the long header uses bits 9:8, and the long second byte uses bits 7:0. With an all-zero mask, the compare is exact.
- R4: With promisc_en_i = 1 the mask is ignored. Every short-mode first byte is accepted, except 0x00. In long mode a header only needs the prefix 11110 in bits 7:3, and any second byte is accepted.
- R5: A first byte of 0x00 is a general call. With gcall_en_i = 1 it gives match_o, ack_o and gcall_o = 1. With gcall_en_i = 0 it is never acknowledged, in any mode.
- R6: In long mode, a first byte equal to {11110, own_addr_i[9:8], 0} gives ack_o without match_o. tenbit_busy_o then goes high.
- R7: While tenbit_busy_o is high, the next byte is compared against own_addr_i[7:0]. A hit gives match_o and ack_o with rw_o = 0, and tenbit_busy_o falls in the same clock either way.
- R8: After a completed long write-address match, a repeated START followed by the read header {11110, own_addr_i[9:8], 1} gives match_o, ack_o and rw_o = 1. Without that earlier match, the read header is not acknowledged.
- R9: A byte that does not match gets no ack. It clears the long sequence state, and every byte up to the next START is ignored.
- R10: STOP clears tenbit_busy_o, gcall_o and rw_o. A START that follows a STOP clears the completed-write state. START also clears gcall_o and rw_o.
- R11: A strobe outside the address phase gives no ack. This covers a strobe with no START seen and a strobe after a decision.
- R12: A strobe in the same cycle as START or STOP is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | START or repeated START pulse |
| stop_i | input | 1 | STOP pulse |
| byte_vld_i | input | 1 | Received-byte strobe |
| byte_i | input | 8 | Received byte, bit 0 is R/W in a first byte |
| own_addr_i | input | 10 | Own slave address |
| addr_mask_i | input | 10 | Don't-care mask, 1 = ignore bit |
| ten_bit_mode_i | input | 1 | 1 = long (10-bit) addressing |
| promisc_en_i | input | 1 | 1 = accept every address |
| gcall_en_i | input | 1 | 1 = acknowledge general call |
| match_o | output | 1 | Full address match pulse |
| ack_o | output | 1 | Acknowledge pulse for the last byte |
| gcall_o | output | 1 | Last match was a general call |
| rw_o | output | 1 | R/W direction of the last match |
| tenbit_busy_o | output | 1 | Header matched, waiting for the low byte |

## Verification
Short mode is tried with the exact own address in both directions, with a one-bit miss, and then with masks that either cover or miss the differing bits. This shows that the compare is exact and that the mask only widens it. Long mode is tried with a write header and low byte, then a repeated-START read, a read after a fresh START, and a wrong low byte followed by a read. These patterns separate a completed write match from a broken one. The zero byte is sent with general call enabled and disabled and with accept-all on. This shows that the general-call gate takes priority over accept-all. Strobes without a START, after a decision, and coincident with START check that only address-phase bytes are judged.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 10;
  localparam int SHORT_W = BYTE_W - 1;
  localparam int HI_W    = ADDR_W - BYTE_W;
  localparam int PFX_W   = BYTE_W - HI_W - 1;
  localparam logic [PFX_W-1:0] HDR_PFX = PFX_W'(5'b11110);

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } am_phase_e;

  // True when a and b agree on every position whose dc bit is 0.
  function automatic logic bits_agree(input logic [BYTE_W-1:0] a,
                                      input logic [BYTE_W-1:0] b,
                                      input logic [BYTE_W-1:0] dc);
    return ((a ^ b) & ~dc) == '0;
  endfunction

  // Effective don't-care vector: accept-all widens every bit.
  function automatic logic [ADDR_W-1:0] eff_dc(input logic [ADDR_W-1:0] mask,
                                               input logic promisc);
    return promisc ? {ADDR_W{1'b1}} : mask;
  endfunction
endpackage

// File: rtl/am_compare.sv
module am_compare
  import i2c_am_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [ADDR_W-1:0] addr_mask_i,
  input  logic              promisc_en_i,
  output logic              gc_byte_o,
  output logic              hit7_o,
  output logic              hdr_hit_o,
  output logic              low_hit_o
);
  logic [ADDR_W-1:0] dc;
  logic              pfx_ok;
  logic              hi_ok;

  assign dc        = eff_dc(addr_mask_i, promisc_en_i);
  assign gc_byte_o = (byte_i == '0);

  // Short address lives in bits 7:1 of the first byte.
  assign hit7_o = bits_agree({1'b0, byte_i[BYTE_W-1:1]},
                             {1'b0, own_addr_i[SHORT_W-1:0]},
                             {1'b1, dc[SHORT_W-1:0]});

  // Long header: fixed prefix, then the upper address bits, then R/W.
  assign pfx_ok = (byte_i[BYTE_W-1 -: PFX_W] == HDR_PFX);
  assign hi_ok  = bits_agree({{(BYTE_W-HI_W){1'b0}}, byte_i[HI_W:1]},
                             {{(BYTE_W-HI_W){1'b0}}, own_addr_i[ADDR_W-1 -: HI_W]},
                             {{(BYTE_W-HI_W){1'b1}}, dc[ADDR_W-1 -: HI_W]});
  assign hdr_hit_o = pfx_ok & hi_ok;

  // Long second byte: the low eight address bits.
  assign low_hit_o = bits_agree(byte_i, own_addr_i[BYTE_W-1:0], dc[BYTE_W-1:0]);
endmodule

// File: rtl/am_seq.sv
module am_seq
  import i2c_am_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic byte_vld_i,
  input  logic rw_bit_i,
  input  logic ten_bit_mode_i,
  input  logic gcall_en_i,
  input  logic gc_byte_i,
  input  logic hit7_i,
  input  logic hdr_hit_i,
  input  logic low_hit_i,
  output logic ev_ack_o,
  output logic ev_match_o,
  output logic ev_gcall_o,
  output logic ev_rw_o,
  output logic tenbit_busy_o
);
  am_phase_e phase_q, phase_d;
  logic      wr_done_q, wr_done_d;
  logic      bus_busy_q, bus_busy_d;

  // Named internal events.
  logic take, in_first, in_second;
  logic first_full, first_part, full_hit, ev_fail;

  assign take      = byte_vld_i & ~start_i & ~stop_i;
  assign in_first  = take & (phase_q == PH_FIRST);
  assign in_second = take & (phase_q == PH_SECOND);

  always_comb begin
    first_full = 1'b0;
    first_part = 1'b0;
    if (gc_byte_i) begin
      first_full = gcall_en_i;
    end else if (!ten_bit_mode_i) begin
      first_full = hit7_i;
    end else if (hdr_hit_i) begin
      first_part = ~rw_bit_i;
      first_full = rw_bit_i & wr_done_q;
    end
  end

  assign full_hit   = (in_first & first_full) | (in_second & low_hit_i);
  assign ev_match_o = full_hit;
  assign ev_ack_o   = full_hit | (in_first & first_part);
  assign ev_gcall_o = in_first & gc_byte_i & gcall_en_i;
  assign ev_rw_o    = in_first & first_full & rw_bit_i;
  assign ev_fail    = (in_first | in_second) & ~ev_ack_o;

  always_comb begin
    phase_d    = phase_q;
    wr_done_d  = wr_done_q;
    bus_busy_d = bus_busy_q;
    if (stop_i) begin
      phase_d    = PH_IDLE;
      wr_done_d  = 1'b0;
      bus_busy_d = 1'b0;
    end
    if (start_i) begin
      phase_d    = PH_FIRST;
      wr_done_d  = wr_done_q & bus_busy_q & ~stop_i;
      bus_busy_d = 1'b1;
    end else if (in_first) begin
      phase_d = first_part ? PH_SECOND : PH_IDLE;
      if (ev_fail) wr_done_d = 1'b0;
    end else if (in_second) begin
      phase_d   = PH_IDLE;
      wr_done_d = low_hit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      wr_done_q  <= 1'b0;
      bus_busy_q <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      wr_done_q  <= wr_done_d;
      bus_busy_q <= bus_busy_d;
    end
  end

  assign tenbit_busy_o = (phase_q == PH_SECOND);

  p_hdr_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_first && ten_bit_mode_i && hdr_hit_i && !rw_bit_i && !gc_byte_i) |=> tenbit_busy_o);
  p_second_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_second |=> !tenbit_busy_o);
  p_fail_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fail && !start_i) |=> (phase_q == PH_IDLE && !wr_done_q));
  p_stop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> (phase_q == PH_IDLE && !wr_done_q && !bus_busy_q));
  p_idle_ignores_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |-> !ev_ack_o);
  p_read_needs_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_first && ten_bit_mode_i && rw_bit_i && !wr_done_q) |-> !ev_ack_o);
endmodule

// File: rtl/am_outreg.sv
module am_outreg (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic byte_vld_i,
  input  logic gcall_en_i,
  input  logic ev_ack_i,
  input  logic ev_match_i,
  input  logic ev_gcall_i,
  input  logic ev_rw_i,
  output logic match_o,
  output logic ack_o,
  output logic gcall_o,
  output logic rw_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_o <= 1'b0;
      ack_o   <= 1'b0;
      gcall_o <= 1'b0;
      rw_o    <= 1'b0;
    end else begin
      match_o <= ev_match_i;
      ack_o   <= ev_ack_i;
      if (start_i || stop_i) begin
        gcall_o <= 1'b0;
        rw_o    <= 1'b0;
      end else if (ev_match_i) begin
        gcall_o <= ev_gcall_i;
        rw_o    <= ev_rw_i;
      end
    end
  end

  p_match_has_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> ack_o);
  p_gcall_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && gcall_o) |-> $past(gcall_en_i));
  p_ack_after_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(byte_vld_i));
  p_ctl_masks_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i || stop_i) |=> (!ack_o && !gcall_o && !rw_o));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [ADDR_W-1:0] addr_mask_i,
  input  logic              ten_bit_mode_i,
  input  logic              promisc_en_i,
  input  logic              gcall_en_i,
  output logic              match_o,
  output logic              ack_o,
  output logic              gcall_o,
  output logic              rw_o,
  output logic              tenbit_busy_o
);
  logic gc_byte, hit7, hdr_hit, low_hit;
  logic ev_ack, ev_match, ev_gcall, ev_rw;

  am_compare u_cmp (
    .byte_i       (byte_i),
    .own_addr_i   (own_addr_i),
    .addr_mask_i  (addr_mask_i),
    .promisc_en_i (promisc_en_i),
    .gc_byte_o    (gc_byte),
    .hit7_o       (hit7),
    .hdr_hit_o    (hdr_hit),
    .low_hit_o    (low_hit)
  );

  am_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .stop_i         (stop_i),
    .byte_vld_i     (byte_vld_i),
    .rw_bit_i       (byte_i[0]),
    .ten_bit_mode_i (ten_bit_mode_i),
    .gcall_en_i     (gcall_en_i),
    .gc_byte_i      (gc_byte),
    .hit7_i         (hit7),
    .hdr_hit_i      (hdr_hit),
    .low_hit_i      (low_hit),
    .ev_ack_o       (ev_ack),
    .ev_match_o     (ev_match),
    .ev_gcall_o     (ev_gcall),
    .ev_rw_o        (ev_rw),
    .tenbit_busy_o  (tenbit_busy_o)
  );

  am_outreg u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .byte_vld_i (byte_vld_i),
    .gcall_en_i (gcall_en_i),
    .ev_ack_i   (ev_ack),
    .ev_match_i (ev_match),
    .ev_gcall_i (ev_gcall),
    .ev_rw_i    (ev_rw),
    .match_o    (match_o),
    .ack_o      (ack_o),
    .gcall_o    (gcall_o),
    .rw_o       (rw_o)
  );

  p_busy_only_long_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tenbit_busy_o) |-> ($past(ten_bit_mode_i) && ack_o && !match_o));
endmodule

// File: tb/i2c_addr_match_bench.sv
module i2c_addr_match_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic [9:0] own_addr_i = 10'h2A5;
  logic [9:0] addr_mask_i = 10'h000;
  logic       ten_bit_mode_i = 1'b0, promisc_en_i = 1'b0, gcall_en_i = 1'b0;
  logic       match_o, ack_o, gcall_o, rw_o, tenbit_busy_o;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  i2c_addr_match u_i2c_addr_match (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .own_addr_i(own_addr_i),
    .addr_mask_i(addr_mask_i), .ten_bit_mode_i(ten_bit_mode_i),
    .promisc_en_i(promisc_en_i), .gcall_en_i(gcall_en_i),
    .match_o(match_o), .ack_o(ack_o), .gcall_o(gcall_o), .rw_o(rw_o),
    .tenbit_busy_o(tenbit_busy_o)
  );

  // Behavioural reference: 0 = not listening, 1 = first byte, 2 = low byte.
  int m_step = 0;
  bit m_wr = 0, m_open = 0;
  bit e_match = 0, e_ack = 0, e_gc = 0, e_rw = 0;

  function automatic bit same_bits(int a, int b, int dc, int width);
    for (int i = 0; i < width; i++)
      if (!dc[i] && (a[i] != b[i])) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_step = 0; m_wr = 0; m_open = 0;
      e_match = 0; e_ack = 0; e_gc = 0; e_rw = 0;
    end else begin
      automatic int dc = promisc_en_i ? 32'h3FF : int'(addr_mask_i);
      automatic int b  = int'(byte_i);
      automatic int ow = int'(own_addr_i);
      automatic bit ok = 0, part = 0;
      e_match = 0; e_ack = 0;
      if (stop_i) begin
        m_step = 0; m_wr = 0; m_open = 0; e_gc = 0; e_rw = 0;
      end
      if (start_i) begin
        if (!m_open) m_wr = 0;
        m_open = 1; m_step = 1; e_gc = 0; e_rw = 0;
      end else if (!stop_i && byte_vld_i && m_step == 1) begin
        if (b == 0) begin
          ok = gcall_en_i;
          if (ok) begin e_gc = 1; e_rw = 0; end
        end else if (!ten_bit_mode_i) begin
          ok = same_bits(b / 2, ow % 128, dc % 128, 7);
          if (ok) begin e_gc = 0; e_rw = b[0]; end
        end else if ((b / 8) == 30 && same_bits((b / 2) % 4, ow / 256, dc / 256, 2)) begin
          if (b[0] == 0) part = 1;
          else if (m_wr) begin ok = 1; e_gc = 0; e_rw = 1; end
        end
        e_match = ok; e_ack = ok | part;
        m_step  = part ? 2 : 0;
        if (!(ok | part)) m_wr = 0;
      end else if (!stop_i && byte_vld_i && m_step == 2) begin
        ok = same_bits(b, ow % 256, dc % 256, 8);
        e_match = ok; e_ack = ok;
        if (ok) begin e_gc = 0; e_rw = 0; end
        m_wr = ok; m_step = 0;
      end
    end
  end

  // Whole-output comparison on every falling edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic logic [4:0] act = {match_o, ack_o, gcall_o, rw_o, tenbit_busy_o};
      automatic logic [4:0] exp = {e_match, e_ack, e_gc, e_rw, (m_step == 2)};
      n_tests++;
      if (act !== exp) begin
        n_fail++;
        $display("FAIL %s model compare: actual %b expected %b", cur_req, act, exp);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input bit s, input bit p, input bit v, input logic [7:0] b);
    start_i = s; stop_i = p; byte_vld_i = v; byte_i = b;
    @(negedge clk);
    start_i = 0; stop_i = 0; byte_vld_i = 0;
  endtask

  task automatic sb(input logic [7:0] b, input bit exp_ack, input bit exp_match, input string req);
    cur_req = req;
    drive(0, 0, 1, b);
    chk(req, {6'd0, ack_o, match_o}, {6'd0, exp_ack, exp_match});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", {3'd0, match_o, ack_o, gcall_o, rw_o, tenbit_busy_o}, 8'h00);

    // R11: strobe before any START
    sb(8'h4A, 0, 0, "R11");
    // R2: short exact write and read
    drive(1, 0, 0, 8'h00); sb(8'h4A, 1, 1, "R2"); chk("R2", {7'd0, rw_o}, 8'h00);
    sb(8'h4A, 0, 0, "R11");
    drive(0, 1, 0, 8'h00);
    drive(1, 0, 0, 8'h00); sb(8'h4B, 1, 1, "R2"); chk("R2", {7'd0, rw_o}, 8'h01);
    drive(0, 1, 0, 8'h00);
    chk("R10", {7'd0, rw_o}, 8'h00);
    // R9: miss then own address ignored
    drive(1, 0, 0, 8'h00); sb(8'h4C, 0, 0, "R9"); sb(8'h4A, 0, 0, "R9");
    drive(0, 1, 0, 8'h00);
    // R3: mask covers bits 1:0, not bit 3
    addr_mask_i = 10'h003;
    drive(1, 0, 0, 8'h00); sb(8'h4C, 1, 1, "R3"); drive(0, 1, 0, 8'h00);
    drive(1, 0, 0, 8'h00); sb(8'h5A, 0, 0, "R3"); drive(0, 1, 0, 8'h00);
    addr_mask_i = 10'h000;
    // R4: accept-all
    promisc_en_i = 1;
    drive(1, 0, 0, 8'h00); sb(8'h10, 1, 1, "R4"); drive(0, 1, 0, 8'h00);
    // R5: general call gated even in accept-all
    drive(1, 0, 0, 8'h00); sb(8'h00, 0, 0, "R5"); drive(0, 1, 0, 8'h00);
    gcall_en_i = 1;
    drive(1, 0, 0, 8'h00); sb(8'h00, 1, 1, "R5"); chk("R5", {7'd0, gcall_o}, 8'h01);
    drive(0, 1, 0, 8'h00); chk("R10", {7'd0, gcall_o}, 8'h00);
    promisc_en_i = 0;

    // Long mode, own 0x2A5: header write 0xF4, read 0xF5, low 0xA5
    ten_bit_mode_i = 1;
    drive(1, 0, 0, 8'h00); sb(8'hF4, 1, 0, "R6"); chk("R6", {7'd0, tenbit_busy_o}, 8'h01);
    sb(8'hA5, 1, 1, "R7"); chk("R7", {6'd0, tenbit_busy_o, rw_o}, 8'h00);
    drive(1, 0, 0, 8'h00); sb(8'hF5, 1, 1, "R8"); chk("R8", {7'd0, rw_o}, 8'h01);
    drive(0, 1, 0, 8'h00);
    // R8/R10: read after a fresh START is refused
    drive(1, 0, 0, 8'h00); sb(8'hF5, 0, 0, "R10"); drive(0, 1, 0, 8'h00);
    // R9: wrong low byte, then read refused
    drive(1, 0, 0, 8'h00); sb(8'hF4, 1, 0, "R9"); sb(8'hA6, 0, 0, "R9");
    chk("R9", {7'd0, tenbit_busy_o}, 8'h00);
    drive(1, 0, 0, 8'h00); sb(8'hF5, 0, 0, "R9"); drive(0, 1, 0, 8'h00);
    // R9: wrong header bits
    drive(1, 0, 0, 8'h00); sb(8'hF6, 0, 0, "R9"); drive(0, 1, 0, 8'h00);
    // R3: mask bit 8 in long mode
    addr_mask_i = 10'h100;
    drive(1, 0, 0, 8'h00); sb(8'hF6, 1, 0, "R3"); sb(8'hA5, 1, 1, "R3");
    drive(0, 1, 0, 8'h00);
    addr_mask_i = 10'h000;
    // R10: STOP in the middle of a long sequence
    drive(1, 0, 0, 8'h00); sb(8'hF4, 1, 0, "R10"); drive(0, 1, 0, 8'h00);
    chk("R10", {7'd0, tenbit_busy_o}, 8'h00);
    // R4: accept-all long mode
    promisc_en_i = 1;
    drive(1, 0, 0, 8'h00); sb(8'hF0, 1, 0, "R4"); sb(8'h00, 1, 1, "R4");
    drive(0, 1, 0, 8'h00);
    promisc_en_i = 0; ten_bit_mode_i = 0;

    // R12: strobe together with START, then with STOP
    cur_req = "R12";
    drive(1, 0, 1, 8'h4A); chk("R12", {7'd0, ack_o}, 8'h00);
    drive(0, 1, 1, 8'h4A); chk("R12", {7'd0, ack_o}, 8'h00);
    drive(1, 0, 0, 8'h00); sb(8'h4A, 1, 1, "R12");
    drive(0, 1, 0, 8'h00);

    repeat (2) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule